// File: doc/BRIEF.md
# Downstream Port Power Switch Controller

This block drives the enable pins of the external power switches that feed four downstream ports of a hub. It also watches the active-low overcurrent flag that each switch returns. Hub logic asks for power on each port, and the block turns that request into a switch-control level. The polarity of that level is chosen by configuration. The block removes power when a switch reports a fault that has lasted long enough.

Three configuration bits are latched elsewhere and treated as static here. The first enables power management; when it is clear, switching and fault monitoring are both unsupported. The second selects ganged control, in which all ports share one power state, or individual control, in which each port has its own. The third selects an active-high or active-low switch pin. A filter length sets how many extra clock samples an overcurrent flag must stay low before it is reported.

A reported fault sets a sticky per-port status bit and cuts power to the port, or to every port in ganged mode. The bit stays set until a clear pulse arrives from software or the block is reset. The block also tells the charging logic whether battery charging is allowed. Charging needs power switching to be enabled and individual control to be selected.

Top module: `port_pwr_ctrl`

## Requirements
- R1: While rst_n is low, every switch pin is at its inactive level and every oc_flag bit is 0.
- R2: In individual mode with cfg_mgmt_en=1, sw_pin[i] reaches its active level after the first clock edge that samples pwr_req[i]=1. It returns to inactive after the first edge that samples pwr_req[i]=0. The other ports are unaffected.
- R3: In ganged mode with cfg_mgmt_en=1, all switch pins are active after the first edge at which any pwr_req bit is 1. All are inactive after the first edge at which no bit is 1.
- R4: With cfg_pol_high=1 an active pin is 1 and an inactive pin is 0. With cfg_pol_high=0 an active pin is 0 and an inactive pin is 1.
- R5: oc_n[i]=0 means an overcurrent. A fault is reported only if oc_n[i] is sampled low on filt_len+1 consecutive rising edges. Counting the first such edge as edge 1, oc_flag[i] is set after edge filt_len+3. A low pulse covering only filt_len samples sets nothing.
- R6: In individual mode a reported fault on port i drives sw_pin[i] inactive on the same edge that sets oc_flag[i]. The other ports keep their state.
- R7: In ganged mode a fault reported on any port drives all switch pins inactive. Only that port's oc_flag bit is set.
- R8: oc_flag[i] stays set after oc_n[i] returns high. A one-cycle oc_clr[i]=1 pulse clears it after that edge. The port's switch comes back one edge later if it is still requested. If a fault is qualified in the same cycle as the clear, the flag stays set.
- R9: With cfg_mgmt_en=0, all switch pins are held inactive and oc_n is ignored: no oc_flag bit becomes set.
- R10: chg_ok is 1 exactly when cfg_mgmt_en=1 and cfg_ganged=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mgmt_en | input | 1 | 1 = power switching and overcurrent monitoring supported |
| cfg_ganged | input | 1 | 1 = one shared power state for all ports |
| cfg_pol_high | input | 1 | 1 = switch pins active high, 0 = active low |
| filt_len | input | FILT_W (8) | Extra low samples required before a fault is reported |
| pwr_req | input | NUM_PORTS (4) | Per-port power-on request from hub logic |
| oc_n | input | NUM_PORTS (4) | Active-low overcurrent flags from the switches |
| oc_clr | input | NUM_PORTS (4) | Software clear pulse, one bit per status bit |
| sw_pin | output | NUM_PORTS (4) | Switch-control pins |
| oc_flag | output | NUM_PORTS (4) | Sticky overcurrent status |
| chg_ok | output | 1 | Battery charging permitted by the configuration |

## Verification
A request change appears on the switch pins one edge after it is sampled, because one state register sits between them. An overcurrent passes a two-flop synchronizer and the filter counter, so its flag and the power cut land on edge filt_len+3, counted from the first edge that samples the low level. A clear acts on the next edge, and power returns one edge after that. The bench drives inputs on falling edges and checks on the falling edge after the counted rising edge. It also checks the edge just before each fault is due, so that an early report is caught as well as a late one.

// File: rtl/ppc_pkg.sv
`timescale 1ns/1ps
// Package: shared configuration type for the port power controller.
// Assumes configuration bits are static between resets.
package ppc_pkg;
    typedef struct packed {
        logic mgmt_en;   // switching and monitoring supported
        logic ganged;    // shared power state
        logic pol_high;  // active-high switch pins
    } ppc_cfg_t;
endpackage

// File: rtl/ppc_oc_filter.sv
`timescale 1ns/1ps
// Module: ppc_oc_filter
// Synchronizes one active-low overcurrent flag and qualifies it once it
// has been low for filt_len+1 consecutive samples. Assumes oc_n is
// asynchronous to clk and that filt_len changes only while idle.
module ppc_oc_filter #(
    parameter int FILT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [FILT_W-1:0] filt_len,
    input  logic              oc_n,
    output logic              qual
);
    localparam logic [FILT_W-1:0] CNT_MAX = {FILT_W{1'b1}};

    logic              sync1_q, sync2_q;
    logic [FILT_W-1:0] run_q;
    logic              low_now;

    // Two-flop synchronizer; resets to the no-fault level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= 1'b1;
            sync2_q <= 1'b1;
        end else begin
            sync1_q <= oc_n;
            sync2_q <= sync1_q;
        end
    end

    assign low_now = enable && !sync2_q;

    // Saturating count of consecutive low cycles seen before this one.
    always_ff @(posedge clk) begin
        if (!rst_n || !low_now) begin
            run_q <= '0;
        end else if (run_q != CNT_MAX) begin
            run_q <= run_q + 1'b1;
        end
    end

    // Fault is qualified once enough earlier low cycles have been counted.
    always_comb begin
        qual = low_now && (run_q >= filt_len);
    end
endmodule

// File: rtl/ppc_fault_latch.sv
`timescale 1ns/1ps
// Module: ppc_fault_latch
// Holds the sticky per-port overcurrent status. A qualified fault sets a
// bit; a clear pulse resets it; a set wins over a clear in the same cycle.
module ppc_fault_latch #(
    parameter int NUM_PORTS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] set_v,
    input  logic [NUM_PORTS-1:0] clr_v,
    output logic [NUM_PORTS-1:0] flag_q
);
    // Sticky status update with set priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q <= (flag_q & ~clr_v) | set_v;
        end
    end
endmodule

// File: rtl/ppc_switch_ctrl.sv
`timescale 1ns/1ps
// Module: ppc_switch_ctrl
// Computes the registered on/off state of each port switch from the
// requests, the current status and faults qualified this cycle.
// Assumes cfg is static; ganged mode forms one shared state.
module ppc_switch_ctrl
    import ppc_pkg::*;
#(
    parameter int NUM_PORTS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  ppc_cfg_t             cfg,
    input  logic [NUM_PORTS-1:0] req,
    input  logic [NUM_PORTS-1:0] flag_q,
    input  logic [NUM_PORTS-1:0] qual,
    output logic [NUM_PORTS-1:0] on_q
);
    logic [NUM_PORTS-1:0] blocked;
    logic [NUM_PORTS-1:0] on_next;

    // Next switch state per mode.
    always_comb begin
        blocked = flag_q | qual;
        if (!cfg.mgmt_en) begin
            on_next = '0;
        end else if (cfg.ganged) begin
            on_next = ((|req) && !(|blocked)) ? {NUM_PORTS{1'b1}} : '0;
        end else begin
            on_next = req & ~blocked;
        end
    end

    // Switch state register, all off in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            on_q <= '0;
        end else begin
            on_q <= on_next;
        end
    end
endmodule

// File: rtl/ppc_pin_drive.sv
`timescale 1ns/1ps
// Module: ppc_pin_drive
// Maps the internal switch state to pin levels per the polarity bit.
// Inputs come straight from registers, so the pins do not glitch.
module ppc_pin_drive #(
    parameter int NUM_PORTS = 4
) (
    input  logic                 pol_high,
    input  logic [NUM_PORTS-1:0] on_q,
    output logic [NUM_PORTS-1:0] pin
);
    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_pin
        // Per-pin polarity mapping.
        always_comb begin
            pin[g] = pol_high ? on_q[g] : !on_q[g];
        end
    end
endmodule

// File: rtl/port_pwr_ctrl.sv
`timescale 1ns/1ps
// Module: port_pwr_ctrl (top)
// Downstream port power switch controller: per-port overcurrent filters,
// sticky status, individual or ganged switch state and polarity mapping.
// Assumes configuration inputs are latched elsewhere and held static.
module port_pwr_ctrl
    import ppc_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int FILT_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_mgmt_en,
    input  logic                 cfg_ganged,
    input  logic                 cfg_pol_high,
    input  logic [FILT_W-1:0]    filt_len,
    input  logic [NUM_PORTS-1:0] pwr_req,
    input  logic [NUM_PORTS-1:0] oc_n,
    input  logic [NUM_PORTS-1:0] oc_clr,
    output logic [NUM_PORTS-1:0] sw_pin,
    output logic [NUM_PORTS-1:0] oc_flag,
    output logic                 chg_ok
);
    ppc_cfg_t             cfg;
    logic [NUM_PORTS-1:0] qual;
    logic [NUM_PORTS-1:0] on_q;

    // Bundle the configuration bits.
    always_comb begin
        cfg.mgmt_en  = cfg_mgmt_en;
        cfg.ganged   = cfg_ganged;
        cfg.pol_high = cfg_pol_high;
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_filt
        ppc_oc_filter #(.FILT_W(FILT_W)) filt_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .enable   (cfg.mgmt_en),
            .filt_len (filt_len),
            .oc_n     (oc_n[p]),
            .qual     (qual[p])
        );
    end

    ppc_fault_latch #(.NUM_PORTS(NUM_PORTS)) latch_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_v  (qual),
        .clr_v  (oc_clr),
        .flag_q (oc_flag)
    );

    ppc_switch_ctrl #(.NUM_PORTS(NUM_PORTS)) sw_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .cfg    (cfg),
        .req    (pwr_req),
        .flag_q (oc_flag),
        .qual   (qual),
        .on_q   (on_q)
    );

    ppc_pin_drive #(.NUM_PORTS(NUM_PORTS)) pin_i (
        .pol_high (cfg.pol_high),
        .on_q     (on_q),
        .pin      (sw_pin)
    );

    // Charging needs switching support and per-port control.
    always_comb begin
        chg_ok = cfg.mgmt_en && !cfg.ganged;
    end
endmodule

// File: rtl/ppc_chk.sv
`timescale 1ns/1ps
// Module: ppc_chk
// Property checker for port_pwr_ctrl, attached by bind below.
module ppc_chk #(
    parameter int NUM_PORTS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cfg_mgmt_en,
    input logic                 cfg_ganged,
    input logic                 cfg_pol_high,
    input logic [NUM_PORTS-1:0] oc_clr,
    input logic [NUM_PORTS-1:0] sw_pin,
    input logic [NUM_PORTS-1:0] oc_flag
);
    logic [NUM_PORTS-1:0] idle_lvl;

    // Inactive pin level for the current polarity.
    always_comb begin
        idle_lvl = cfg_pol_high ? '0 : {NUM_PORTS{1'b1}};
    end

    // R9
    off_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_mgmt_en |=> (sw_pin == idle_lvl));

    // R9
    no_flag_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_mgmt_en |=> ((oc_flag & ~$past(oc_flag)) == '0));

    // R6
    flagged_port_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_ganged |-> (((sw_pin ^ idle_lvl) & oc_flag) == '0));

    // R7
    ganged_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ganged && (|oc_flag)) |-> (sw_pin == idle_lvl));

    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(oc_flag & ~oc_clr)) |=>
            ((oc_flag & $past(oc_flag & ~oc_clr)) == $past(oc_flag & ~oc_clr)));
endmodule

bind port_pwr_ctrl ppc_chk #(.NUM_PORTS(NUM_PORTS)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_mgmt_en  (cfg_mgmt_en),
    .cfg_ganged   (cfg_ganged),
    .cfg_pol_high (cfg_pol_high),
    .oc_clr       (oc_clr),
    .sw_pin       (sw_pin),
    .oc_flag      (oc_flag)
);

// File: tb/port_pwr_ctrl_tb_top.sv
`timescale 1ns/1ps
// Directed bench for port_pwr_ctrl: one task per scenario.
module port_pwr_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_mgmt_en, cfg_ganged, cfg_pol_high;
    logic [7:0] filt_len;
    logic [3:0] pwr_req, oc_n, oc_clr;
    logic [3:0] sw_pin, oc_flag;
    logic       chg_ok;
    int         n_chk = 0;
    int         n_bad = 0;

    always #10 clk = ~clk;

    port_pwr_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_mgmt_en(cfg_mgmt_en),
        .cfg_ganged(cfg_ganged), .cfg_pol_high(cfg_pol_high),
        .filt_len(filt_len), .pwr_req(pwr_req), .oc_n(oc_n),
        .oc_clr(oc_clr), .sw_pin(sw_pin), .oc_flag(oc_flag), .chg_ok(chg_ok)
    );

    task automatic chk(input string tag, input logic [3:0] got, input logic [3:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%b exp=%b", tag, got, exp);
        end
    endtask

    // Wait k rising edges, then land on the following falling edge.
    task automatic edges(input int k);
        for (int i = 0; i < k; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; cfg_mgmt_en = 1'b1; cfg_ganged = 1'b0; cfg_pol_high = 1'b1;
        filt_len = 8'd3; pwr_req = 4'hF; oc_n = 4'h0; oc_clr = 4'h0;
        edges(3);
        chk("R1 reset pins high-pol", sw_pin, 4'b0000);
        chk("R1 reset flags", oc_flag, 4'b0000);
        cfg_pol_high = 1'b0;
        edges(1);
        chk("R1 R4 reset pins low-pol", sw_pin, 4'b1111);
        cfg_pol_high = 1'b1; pwr_req = 4'h0; oc_n = 4'hF;
        edges(1);
        rst_n = 1'b1;
        edges(4);
    endtask

    task automatic t_individual();
        pwr_req = 4'b0101;
        edges(1);
        chk("R2 individual 0101", sw_pin, 4'b0101);
        pwr_req = 4'b1010;
        edges(1);
        chk("R2 individual 1010", sw_pin, 4'b1010);
        chk("R10 charging allowed", {3'b0, chg_ok}, 4'b0001);
    endtask

    task automatic t_polarity();
        cfg_pol_high = 1'b0; pwr_req = 4'b0011;
        edges(1);
        chk("R4 active-low pins", sw_pin, 4'b1100);
        cfg_pol_high = 1'b1;
        edges(1);
        chk("R4 active-high pins", sw_pin, 4'b0011);
    endtask

    task automatic t_ganged();
        cfg_ganged = 1'b1; pwr_req = 4'b0100;
        edges(1);
        chk("R3 ganged any request", sw_pin, 4'b1111);
        chk("R10 ganged forbids charging", {3'b0, chg_ok}, 4'b0000);
        pwr_req = 4'b0000;
        edges(1);
        chk("R3 ganged no request", sw_pin, 4'b0000);
        cfg_ganged = 1'b0;
    endtask

    task automatic t_filter();
        filt_len = 8'd3; pwr_req = 4'hF;
        edges(1);
        oc_n[0] = 1'b0;            // glitch of 3 samples
        edges(3);
        oc_n[0] = 1'b1;
        edges(8);
        chk("R5 short glitch ignored flag", oc_flag, 4'b0000);
        chk("R5 short glitch ignored pins", sw_pin, 4'b1111);
        oc_n[0] = 1'b0;            // held: first sample at edge 1
        edges(5);
        chk("R5 not yet reported at edge 5", oc_flag, 4'b0000);
        chk("R6 still powered at edge 5", sw_pin, 4'b1111);
        edges(1);
        chk("R5 reported at edge 6", oc_flag, 4'b0001);
        chk("R6 only faulting port off", sw_pin, 4'b1110);
        oc_n[0] = 1'b1;
        edges(6);
        chk("R8 flag sticky after release", oc_flag, 4'b0001);
        chk("R8 port stays off", sw_pin, 4'b1110);
        oc_clr = 4'b0001;
        edges(1);
        oc_clr = 4'b0000;
        chk("R8 flag cleared", oc_flag, 4'b0000);
        chk("R8 power not yet back", sw_pin, 4'b1110);
        edges(1);
        chk("R8 power restored", sw_pin, 4'b1111);
    endtask

    task automatic t_clear_during_fault();
        filt_len = 8'd0;
        oc_n[1] = 1'b0;
        edges(3);
        chk("R5 zero length reports at edge 3", oc_flag, 4'b0010);
        oc_clr = 4'b0010;
        edges(1);
        oc_clr = 4'b0000;
        chk("R8 set wins over clear", oc_flag, 4'b0010);
        oc_n[1] = 1'b1;
        edges(4);
        oc_clr = 4'b0010;
        edges(1);
        oc_clr = 4'b0000;
        edges(1);
        chk("R8 cleared after release", oc_flag, 4'b0000);
        chk("R8 port 1 back on", sw_pin, 4'b1111);
    endtask

    task automatic t_ganged_fault();
        cfg_ganged = 1'b1; pwr_req = 4'b0001; filt_len = 8'd0;
        edges(1);
        chk("R3 ganged on", sw_pin, 4'b1111);
        oc_n[2] = 1'b0;
        edges(2);
        chk("R7 not yet at edge 2", sw_pin, 4'b1111);
        edges(1);
        chk("R7 only port 2 flagged", oc_flag, 4'b0100);
        chk("R7 all switches off", sw_pin, 4'b0000);
        oc_n[2] = 1'b1;
        edges(4);
        oc_clr = 4'b0100;
        edges(1);
        oc_clr = 4'b0000;
        edges(1);
        chk("R7 ganged restored after clear", sw_pin, 4'b1111);
        cfg_ganged = 1'b0;
    endtask

    task automatic t_disabled();
        cfg_mgmt_en = 1'b0; pwr_req = 4'hF; filt_len = 8'd0;
        edges(1);
        chk("R9 disabled pins inactive", sw_pin, 4'b0000);
        chk("R10 disabled forbids charging", {3'b0, chg_ok}, 4'b0000);
        oc_n[3] = 1'b0;
        edges(20);
        chk("R9 overcurrent ignored", oc_flag, 4'b0000);
        cfg_pol_high = 1'b0;
        edges(1);
        chk("R9 R4 disabled low-pol inactive", sw_pin, 4'b1111);
        oc_n[3] = 1'b1;
        cfg_pol_high = 1'b1;
    endtask

    initial begin
        #(200000 * 20);
        n_chk++; n_bad++;
        $display("FAIL watchdog R1..all got=hang exp=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_individual();
        t_polarity();
        t_ganged();
        t_filter();
        t_clear_during_fault();
        t_ganged_fault();
        t_disabled();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule